// File: doc/BRIEF.md
# Latched Status and Interrupt Controller

This block gathers alarm activity from a line-interface device into a set of 8-bit status registers. Each source bit is either an event type, which latches on a rising edge of its input, or a condition type, which latches on level and keeps being set while the condition lasts. Every status register has a mask register of equal width. A single active-high interrupt line is raised while any latched bit has its mask bit set. A summary register holds one bit per status register, so the host can tell which registers need service.

Status reads are selective. The host first writes a select byte to the status address and then reads that address. For each 1 in the select byte, the readable snapshot bit takes the latched value and the latch is cleared. For each 0, the snapshot bit keeps its old value. A condition that is still present sets its latch again at once. An event sets its latch again only on a new rising edge.

The host uses a simple synchronous register bus. A write takes effect at the clock edge where the write strobe is sampled. Read data appears on the cycle after the read strobe.

Top module: `stat_irq_ctrl`

## Requirements
- R1: A latched status bit drives the interrupt and its summary bit only while its mask bit is 1. A masked latched bit leaves the interrupt output low and the summary register at zero.
- R2: After reset, all status snapshots, all masks, the summary register and the interrupt output read zero.
- R3: A latched status bit stays 1 until a select write to its register has a 1 in that bit position.
- R4: A select write with a 1 clears an event-type latch bit. That bit is not set again until the event input rises again.
- R5: A condition-type bit (by default bits 1:0 of every status register) is set again after a clearing write while its input is still high. After the input falls, the bit clears on the next clearing write.
- R6: In a select write, a 1 in a bit position loads the snapshot bit from the latch. A 0 leaves the snapshot bit unchanged.
- R7: Bit n of the summary register (address 8) is 1 when status register n has at least one latched bit whose mask bit is set.
- R8: Writing zero to all masks makes the interrupt output go low. Restoring a mask makes it go high again if its bits are still latched.
- R9: If an event edge arrives in the same cycle as a clearing write to its bit, the latch stays 1.
- R10: An event input held high latches only once, on its rising edge. A condition input latches on its level.
- R11: The interrupt output is registered. It changes one clock after the masked latch state changes.
- R12: Addresses 0 to 3 are the status registers, 4 to 7 the masks and 8 the summary register. Writes to address 8 are ignored. Reads of unmapped addresses return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| alarm_i | input | 32 | Alarm sources; bit 8n+b feeds bit b of status register n |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 4 | Register address |
| bus_wdata_i | input | 8 | Write data (select byte for status addresses) |
| bus_rdata_o | output | 8 | Read data, valid the cycle after the read strobe |
| irq_o | output | 1 | Active-high interrupt |

## Verification
The bench drives single-cycle event pulses, event inputs held high, and condition inputs that stay high and are then released. Each pattern is followed by one or more select-write and read pairs. This separates edge latching from level latching, and read-and-clear from re-assertion by a condition that is still present. Select bytes that refresh only part of a register separate refreshed snapshot bits from held ones. An event edge placed in the same cycle as its clearing write shows whether the occurrence survives. Mask writes of zero and then a restored value, together with summary-register reads, check the interrupt gating and its one-cycle register delay.

// File: rtl/sic_pkg.sv
package sic_pkg;

    // Kind of register decoded from a host address
    typedef enum logic [1:0] {
        KIND_STAT = 2'd0,
        KIND_MASK = 2'd1,
        KIND_SUMM = 2'd2,
        KIND_NONE = 2'd3
    } reg_kind_e;

endpackage

// File: rtl/sic_status_reg.sv
module sic_status_reg #(
    parameter int            W    = 8,
    parameter logic [W-1:0]  COND = 8'h03
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] src_i,
    input  logic         sel_wr_i,
    input  logic [W-1:0] sel_i,
    output logic [W-1:0] latch_o,
    output logic [W-1:0] snap_o
);

    typedef struct packed {
        logic [W-1:0] src;
        logic [W-1:0] lat;
        logic [W-1:0] snap;
    } st_t;

    st_t          s_d, s_q;
    logic [W-1:0] rise_d;
    logic [W-1:0] set_d;
    logic [W-1:0] clr_d;

    always_comb begin
        s_d     = s_q;
        rise_d  = src_i & ~s_q.src;
        set_d   = (rise_d & ~COND) | (src_i & COND);
        clr_d   = sel_wr_i ? sel_i : '0;
        s_d.src = src_i;
        // setting term applied after the clear: a same-cycle occurrence wins
        s_d.lat  = (s_q.lat & ~clr_d) | set_d;
        s_d.snap = (s_q.snap & ~clr_d) | (s_q.lat & clr_d);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign latch_o = s_q.lat;
    assign snap_o  = s_q.snap;

    AST_LATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sel_wr_i |=> ((s_q.lat & $past(s_q.lat)) == $past(s_q.lat))); // R3

    AST_EVT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sel_wr_i |=> ((s_q.lat & $past(sel_i & ~COND & ~rise_d)) == '0)); // R4

    AST_COND_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|(src_i & COND)) |=> ((s_q.lat & $past(src_i & COND)) == $past(src_i & COND))); // R5

    AST_SNAP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sel_wr_i |=> $stable(s_q.snap)); // R6

    AST_NEW_EVT_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sel_wr_i |=> ((s_q.lat & $past(rise_d)) == $past(rise_d))); // R9

endmodule

// File: rtl/sic_host_if.sv
module sic_host_if
    import sic_pkg::*;
#(
    parameter int N      = 4,
    parameter int W      = 8,
    parameter int ADDR_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_i,
    input  logic             rd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [W-1:0]     wdata_i,
    input  logic [N*W-1:0]   latch_i,
    input  logic [N*W-1:0]   snap_i,
    output logic [N-1:0]     stat_wr_o,
    output logic [W-1:0]     rdata_o,
    output logic             irq_o
);

    localparam logic [ADDR_W-1:0] SUMM_ADDR = ADDR_W'(2 * N);

    typedef struct packed {
        logic [N-1:0][W-1:0] mask;
        logic [W-1:0]        rdata;
        logic                irq;
    } st_t;

    st_t          s_d, s_q;
    reg_kind_e    kind_d;
    logic [N-1:0] hit_d;
    logic [N-1:0] pend_d;
    logic [W-1:0] rval_d;

    always_comb begin
        s_d    = s_q;
        kind_d = KIND_NONE;
        hit_d  = '0;
        pend_d = '0;
        rval_d = '0;
        for (int i = 0; i < N; i++) begin
            pend_d[i] = |(latch_i[i*W +: W] & s_q.mask[i]);
            if (addr_i == ADDR_W'(i)) begin
                kind_d   = KIND_STAT;
                hit_d[i] = 1'b1;
            end
            if (addr_i == ADDR_W'(N + i)) begin
                kind_d   = KIND_MASK;
                hit_d[i] = 1'b1;
            end
        end
        if (addr_i == SUMM_ADDR) kind_d = KIND_SUMM;

        for (int i = 0; i < N; i++) begin
            if (hit_d[i] && kind_d == KIND_STAT) rval_d = rval_d | snap_i[i*W +: W];
            if (hit_d[i] && kind_d == KIND_MASK) begin
                rval_d = rval_d | s_q.mask[i];
                if (wr_i) s_d.mask[i] = wdata_i;
            end
        end
        if (kind_d == KIND_SUMM) rval_d[N-1:0] = pend_d;

        if (rd_i) s_d.rdata = rval_d;
        s_d.irq = |pend_d;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    always_comb begin
        for (int i = 0; i < N; i++) begin
            stat_wr_o[i] = wr_i && hit_d[i] && (kind_d == KIND_STAT);
        end
    end

    assign rdata_o = s_q.rdata;
    assign irq_o   = s_q.irq;

    AST_IRQ_MASKED_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.mask == '0) |=> !s_q.irq); // R8

    AST_IRQ_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|pend_d) |=> s_q.irq); // R11

    AST_SUMM_READ_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && addr_i == SUMM_ADDR) |=> $stable(s_q.mask)); // R12

endmodule

// File: rtl/stat_irq_ctrl.sv
module stat_irq_ctrl #(
    parameter int                         NUM_REGS = 4,
    parameter int                         REG_W    = 8,
    parameter int                         ADDR_W   = 4,
    parameter logic [NUM_REGS*REG_W-1:0]  COND_MAP = 32'h0303_0303
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic [NUM_REGS*REG_W-1:0] alarm_i,
    input  logic                      bus_wr_i,
    input  logic                      bus_rd_i,
    input  logic [ADDR_W-1:0]         bus_addr_i,
    input  logic [REG_W-1:0]          bus_wdata_i,
    output logic [REG_W-1:0]          bus_rdata_o,
    output logic                      irq_o
);

    localparam int FLAT_W = NUM_REGS * REG_W;

    logic [FLAT_W-1:0]   latch_w;
    logic [FLAT_W-1:0]   snap_w;
    logic [NUM_REGS-1:0] stat_wr_w;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_stat
        sic_status_reg #(
            .W    (REG_W),
            .COND (COND_MAP[g*REG_W +: REG_W])
        ) u_stat (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .src_i    (alarm_i[g*REG_W +: REG_W]),
            .sel_wr_i (stat_wr_w[g]),
            .sel_i    (bus_wdata_i),
            .latch_o  (latch_w[g*REG_W +: REG_W]),
            .snap_o   (snap_w[g*REG_W +: REG_W])
        );
    end

    sic_host_if #(
        .N      (NUM_REGS),
        .W      (REG_W),
        .ADDR_W (ADDR_W)
    ) u_host (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_i      (bus_wr_i),
        .rd_i      (bus_rd_i),
        .addr_i    (bus_addr_i),
        .wdata_i   (bus_wdata_i),
        .latch_i   (latch_w),
        .snap_i    (snap_w),
        .stat_wr_o (stat_wr_w),
        .rdata_o   (bus_rdata_o),
        .irq_o     (irq_o)
    );

    AST_RESET_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_ni) |-> !irq_o); // R2

endmodule

// File: tb/stat_irq_ctrl_tb.sv
`timescale 1ns/1ps
module stat_irq_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] alarm = '0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [3:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    stat_irq_ctrl u_dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .alarm_i     (alarm),
        .bus_wr_i    (wr),
        .bus_rd_i    (rd),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .irq_o       (irq)
    );

    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    // driver: pushes the expected value, monitor compares it
    task automatic bus_read(input logic [3:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        rd = 1'b1; addr = a;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic sel_read(input logic [3:0] a, input logic [7:0] sel,
                            input logic [7:0] e, input string tag);
        bus_write(a, sel);
        bus_read(a, e, tag);
    endtask

    task automatic pulse(input int b);
        @(negedge clk);
        alarm[b] = 1'b1;
        @(negedge clk);
        alarm[b] = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string tag);
        checks++;
        if (irq !== e) begin
            errors++;
            $display("FAIL %s: irq actual=%0b expected=%0b", tag, irq, e);
        end
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            if (rd) begin
                @(negedge clk);
                if (exp_q.size() != 0) begin
                    logic [7:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    checks++;
                    if (rdata !== e) begin
                        errors++;
                        $display("FAIL %s: rdata actual=%02h expected=%02h", t, rdata, e);
                    end
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 reset state
        chk_irq(1'b0, "R2 irq after reset");
        bus_read(4'd0, 8'h00, "R2 status0 snapshot");
        bus_read(4'd4, 8'h00, "R2 mask0");
        bus_read(4'd8, 8'h00, "R2 summary");

        // R1 masked event does not interrupt
        pulse(4);
        repeat (2) @(negedge clk);
        chk_irq(1'b0, "R1 masked latch");
        bus_read(4'd8, 8'h00, "R1 summary masked");

        // R11 registered interrupt after mask enable
        bus_write(4'd4, 8'h10);
        chk_irq(1'b0, "R11 irq one cycle later");
        @(negedge clk);
        chk_irq(1'b1, "R11 irq raised");
        bus_read(4'd8, 8'h01, "R7 summary reg0");
        bus_read(4'd4, 8'h10, "R12 mask0 readback");

        // R4 read-and-clear of event bit
        sel_read(4'd0, 8'h10, 8'h10, "R3 latched event read");
        @(negedge clk);
        chk_irq(1'b0, "R4 irq after clear");
        sel_read(4'd0, 8'h10, 8'h00, "R4 event cleared");

        // R6 selective refresh
        pulse(4);
        pulse(5);
        sel_read(4'd0, 8'h20, 8'h20, "R6 bit4 held");
        sel_read(4'd0, 8'h10, 8'h30, "R6 bit5 held bit4 refreshed");

        // R5 condition bit
        @(negedge clk); alarm[8] = 1'b1;
        @(negedge clk);
        sel_read(4'd1, 8'h01, 8'h01, "R10 condition level latch");
        sel_read(4'd1, 8'h01, 8'h01, "R5 condition still present");
        @(negedge clk); alarm[8] = 1'b0;
        @(negedge clk);
        sel_read(4'd1, 8'h01, 8'h01, "R5 condition latched after drop");
        sel_read(4'd1, 8'h01, 8'h00, "R5 condition cleared");

        // R9 same-cycle event and clear
        pulse(22);
        @(negedge clk);
        wr = 1'b1; addr = 4'd2; wdata = 8'h40; alarm[22] = 1'b1;
        @(negedge clk);
        wr = 1'b0; alarm[22] = 1'b0;
        bus_read(4'd2, 8'h40, "R9 old occurrence");
        sel_read(4'd2, 8'h40, 8'h40, "R9 new occurrence kept");
        sel_read(4'd2, 8'h40, 8'h00, "R9 cleared afterwards");

        // R10 held event latches once
        @(negedge clk); alarm[31] = 1'b1;
        repeat (3) @(negedge clk);
        sel_read(4'd3, 8'h80, 8'h80, "R10 held event first");
        sel_read(4'd3, 8'h80, 8'h00, "R10 held event no relatch");
        @(negedge clk); alarm[31] = 1'b0;

        // R8 mask clear and restore
        pulse(29);
        @(negedge clk);
        chk_irq(1'b0, "R1 reg3 masked");
        bus_write(4'd7, 8'hFF);
        @(negedge clk);
        chk_irq(1'b1, "R8 irq with mask3");
        bus_read(4'd8, 8'h08, "R7 summary reg3");
        bus_write(4'd8, 8'hFF);
        bus_read(4'd8, 8'h08, "R12 summary write ignored");
        bus_read(4'd7, 8'hFF, "R12 mask3 readback");
        bus_write(4'd7, 8'h00);
        @(negedge clk);
        chk_irq(1'b0, "R8 irq off after mask clear");
        bus_write(4'd7, 8'h20);
        @(negedge clk);
        chk_irq(1'b1, "R8 irq back after restore");
        bus_read(4'd9, 8'h00, "R12 unmapped read");

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule